// File: doc/BRIEF.md
# Command Completion Event Tracker

This block follows one command through a card host controller from the moment it is issued until it ends. When a command is issued, the block samples a small set of attributes: whether the response signals busy, whether data moves, whether the transfer is multi-block, whether it is a write, whether it is stream mode, and whether DMA or programmed I/O moves the data. From these attributes it works out which completion events it must collect. It then gathers single-cycle event pulses until every one of those events has been seen, and reports success.

The five error events are always enabled. Any one of them ends the command at once, whatever events are still missing. The block then reports an error together with a class: timeout or generic failure. While a command is open, the block also drives the interrupt mask that the controller should apply, and it echoes each cycle's event flags back so that the flags can be cleared.

The block holds one command at a time. An issue that arrives while a command is still open is refused with a busy pulse.

Top module: `cmd_done_tracker`

## Requirements
- R1: After reset `active`, `busy_rej`, `done_ok`, `done_err`, `err_timeout` and `evt_clr` are all 0. `irq_mask` equals 0xE0FF for a 16-bit event vector (all ones except the error bits).
- R2: Event bit positions: 0 response end, 1 programming done, 2 data transfer done, 3 auto-stop done, 4 DMA end, 5 transmit FIFO request, 6 receive FIFO request. The wait set always holds bit 0. A busy-signalling response adds bit 1.
- R3: When data is present, the wait set adds bit 3 for multi-block, bit 1 for a write, and bit 2 unless stream mode is set.
- R4: When data is present, DMA adds bit 4. Without DMA, a write adds bit 5 and a read adds bit 6.
- R5: Events accumulate across cycles as an OR. `done_ok` rises in the cycle after the edge that samples the last missing wait event, and not before.
- R6: The error bits are 8 response CRC, 9 read CRC, 10 write CRC, 11 response timeout and 12 read timeout. Any of them during an open command raises `done_err` in the cycle after it is sampled, whatever the wait set holds. `err_timeout` is 1 with it exactly when bit 11 or bit 12 was seen.
- R7: `irq_mask` is the inverse of (error bits OR the current wait set). A 1 masks an event. When no command is open, only the error bits are unmasked.
- R8: An `issue` while `active` is 1 gives a one-cycle `busy_rej` on the next cycle. It leaves the open command, its wait set and its mask unchanged. This includes the cycle in which that command completes.
- R9: Completion clears `active`, the seen set and the wait set on the next edge. Events seen by one command never count toward the next.
- R10: Event pulses present in the same cycle as an accepted `issue` are captured into the new command's seen set.
- R11: Event pulses while no command is open are ignored.
- R12: `evt_clr` equals the `evt_in` value of the previous cycle.
- R13: `done_ok` and `done_err` are one-cycle pulses and are never high together. An error wins over a completion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Start a command; attributes sampled with it |
| need_busy | input | 1 | Response signals busy |
| has_data | input | 1 | Command carries data |
| multi_blk | input | 1 | Multi-block transfer with automatic stop |
| is_write | input | 1 | Data direction is write |
| stream_mode | input | 1 | Stream transfer (no block-done event) |
| use_dma | input | 1 | DMA moves the data (else programmed I/O) |
| evt_in | input | EV_W | Single-cycle event pulses |
| active | output | 1 | A command is open |
| busy_rej | output | 1 | Issue refused because a command was open |
| done_ok | output | 1 | Success pulse |
| done_err | output | 1 | Error pulse |
| err_timeout | output | 1 | Error class is timeout (valid with done_err) |
| irq_mask | output | EV_W | Interrupt mask, 1 masks the event |
| evt_clr | output | EV_W | Write-back value that clears the flags |

## Verification
Every cycle, the assertions check these properties: `done_ok` and `done_err` never rise together, both pulses stay low when no command is open, and a completion always closes the command. They also check that the error bits are never masked, that response end stays unmasked while a command is open, and that refused issues and the flag echo appear one cycle later. The exact wait set that each attribute combination builds can only be shown by the bench's scenarios, which read it back through the mask. The same holds for out-of-order and duplicate event arrival, error class selection, errors that beat a same-cycle completion, capture in the issue cycle, and the loss of events between commands.

// File: rtl/cmd_done_tracker.sv
module cmd_done_tracker #(
  parameter int EV_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic            need_busy,
  input  logic            has_data,
  input  logic            multi_blk,
  input  logic            is_write,
  input  logic            stream_mode,
  input  logic            use_dma,
  input  logic [EV_W-1:0] evt_in,
  output logic            active,
  output logic            busy_rej,
  output logic            done_ok,
  output logic            done_err,
  output logic            err_timeout,
  output logic [EV_W-1:0] irq_mask,
  output logic [EV_W-1:0] evt_clr
);

  localparam int B_RSP     = 0;
  localparam int B_PRG     = 1;
  localparam int B_XFR     = 2;
  localparam int B_ASTOP   = 3;
  localparam int B_DMA     = 4;
  localparam int B_TXQ     = 5;
  localparam int B_RXQ     = 6;
  localparam int B_CRC_RSP = 8;
  localparam int B_CRC_RD  = 9;
  localparam int B_CRC_WR  = 10;
  localparam int B_TO_RSP  = 11;
  localparam int B_TO_RD   = 12;

  localparam logic [EV_W-1:0] ONE     = {{(EV_W-1){1'b0}}, 1'b1};
  localparam logic [EV_W-1:0] TO_SET  = (ONE << B_TO_RSP) | (ONE << B_TO_RD);
  localparam logic [EV_W-1:0] ERR_SET = TO_SET | (ONE << B_CRC_RSP)
                                      | (ONE << B_CRC_RD) | (ONE << B_CRC_WR);

  logic [EV_W-1:0] wait_q, seen_q, wait_new;

  always_comb begin
    wait_new = ONE << B_RSP;
    if (need_busy) wait_new = wait_new | (ONE << B_PRG);
    if (has_data) begin
      if (multi_blk)    wait_new = wait_new | (ONE << B_ASTOP);
      if (is_write)     wait_new = wait_new | (ONE << B_PRG);
      if (!stream_mode) wait_new = wait_new | (ONE << B_XFR);
      if (use_dma)      wait_new = wait_new | (ONE << B_DMA);
      else if (is_write) wait_new = wait_new | (ONE << B_TXQ);
      else              wait_new = wait_new | (ONE << B_RXQ);
    end
  end

  wire hit_err  = |(seen_q & ERR_SET);
  wire all_seen = ((seen_q & wait_q) == wait_q);
  wire accept   = issue & ~active;

  assign done_err    = active & hit_err;
  assign done_ok     = active & all_seen & ~hit_err;
  assign err_timeout = done_err & (|(seen_q & TO_SET));
  assign irq_mask    = ~(ERR_SET | wait_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      wait_q   <= '0;
      seen_q   <= '0;
      busy_rej <= 1'b0;
      evt_clr  <= '0;
    end else begin
      busy_rej <= issue & active;
      evt_clr  <= evt_in;
      if (accept) begin
        active <= 1'b1;
        wait_q <= wait_new;
        seen_q <= evt_in;
      end else if (done_ok | done_err) begin
        active <= 1'b0;
        wait_q <= '0;
        seen_q <= '0;
      end else if (active) begin
        seen_q <= seen_q | evt_in;
      end
    end
  end

endmodule

// File: rtl/cmd_done_tracker_chk.sv
module cmd_done_tracker_chk #(
  parameter int EV_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue,
  input logic [EV_W-1:0] evt_in,
  input logic            active,
  input logic            busy_rej,
  input logic            done_ok,
  input logic            done_err,
  input logic            err_timeout,
  input logic [EV_W-1:0] irq_mask,
  input logic [EV_W-1:0] evt_clr
);

  a_r13_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_err));

  a_r9_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_err) |=> !active);

  a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!done_ok && !done_err));

  a_r8_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && active) |=> busy_rej);

  a_r8_no_spurious_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && active) |=> !busy_rej);

  a_r8_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && active && !done_ok && !done_err) |=> $stable(irq_mask));

  a_r7_errors_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask[12:8] == 5'b0);

  a_r2_resp_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !irq_mask[0]);

  a_r6_class_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> done_err);

  a_r12_flag_echo: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_clr == $past(evt_in)));

endmodule

bind cmd_done_tracker cmd_done_tracker_chk #(.EV_W(EV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .evt_in(evt_in), .active(active),
  .busy_rej(busy_rej), .done_ok(done_ok), .done_err(done_err),
  .err_timeout(err_timeout), .irq_mask(irq_mask), .evt_clr(evt_clr)
);

// File: tb/cmd_done_tracker_test.sv
module cmd_done_tracker_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0, need_busy = 1'b0, has_data = 1'b0, multi_blk = 1'b0;
  logic is_write = 1'b0, stream_mode = 1'b0, use_dma = 1'b0;
  logic [W-1:0] evt_in = '0;
  logic active, busy_rej, done_ok, done_err, err_timeout;
  logic [W-1:0] irq_mask, evt_clr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cmd_done_tracker #(.EV_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .need_busy(need_busy),
    .has_data(has_data), .multi_blk(multi_blk), .is_write(is_write),
    .stream_mode(stream_mode), .use_dma(use_dma), .evt_in(evt_in),
    .active(active), .busy_rej(busy_rej), .done_ok(done_ok),
    .done_err(done_err), .err_timeout(err_timeout), .irq_mask(irq_mask),
    .evt_clr(evt_clr)
  );

  localparam logic [W-1:0] IDLE_MASK = 16'hE0FF;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start(input logic b, input logic d, input logic m,
                       input logic w, input logic s, input logic dm);
    need_busy = b; has_data = d; multi_blk = m;
    is_write = w; stream_mode = s; use_dma = dm;
    issue = 1'b1;
    tick();
    issue = 1'b0;
  endtask

  task automatic pulse(input logic [W-1:0] e);
    evt_in = e;
    tick();
    evt_in = '0;
  endtask

  task automatic t_reset();
    chk("R1 active", active, 0);
    chk("R1 done_ok", done_ok, 0);
    chk("R1 done_err", done_err, 0);
    chk("R1 busy_rej", busy_rej, 0);
    chk("R1 mask", irq_mask, IDLE_MASK);
    chk("R1 evt_clr", evt_clr, 0);
  endtask

  task automatic t_simple();
    start(0, 0, 0, 0, 0, 0);
    chk("R2 active", active, 1);
    chk("R2 mask base", irq_mask, 16'hE0FE);
    chk("R5 not yet", done_ok, 0);
    pulse(16'h0001);
    chk("R5 ok", done_ok, 1);
    chk("R13 no err", done_err, 0);
    tick();
    chk("R13 ok one cycle", done_ok, 0);
    chk("R9 closed", active, 0);
    chk("R7 idle mask", irq_mask, IDLE_MASK);
  endtask

  task automatic t_busy_resp();
    start(1, 0, 0, 0, 0, 0);
    chk("R2 busy mask", irq_mask, 16'hE0FC);
    pulse(16'h0001);
    chk("R5 missing prog", done_ok, 0);
    pulse(16'h0002);
    chk("R5 busy ok", done_ok, 1);
    tick();
  endtask

  task automatic t_dma_read_multi();
    start(0, 1, 1, 0, 0, 1);
    chk("R3 R4 mask", irq_mask, 16'hE0E2);
    pulse(16'h0010);
    chk("R5 partial a", done_ok, 0);
    pulse(16'h0001);
    pulse(16'h0010);
    chk("R5 partial b", done_ok, 0);
    pulse(16'h0004);
    chk("R5 partial c", done_ok, 0);
    pulse(16'h0008);
    chk("R5 all seen", done_ok, 1);
    tick();
  endtask

  task automatic t_pio_stream();
    start(0, 1, 0, 1, 1, 0);
    chk("R4 write pio stream mask", irq_mask, 16'hE0DC);
    pulse(16'h0023);
    chk("R5 write done", done_ok, 1);
    tick();
    start(0, 1, 0, 0, 1, 0);
    chk("R4 read pio stream mask", irq_mask, 16'hE0BE);
    pulse(16'h0041);
    chk("R5 read done", done_ok, 1);
    tick();
  endtask

  task automatic t_errors();
    start(0, 1, 0, 0, 0, 1);
    pulse(16'h0200);
    chk("R6 crc err", done_err, 1);
    chk("R6 crc class", err_timeout, 0);
    chk("R13 ok low", done_ok, 0);
    tick();
    chk("R13 err one cycle", done_err, 0);
    chk("R9 closed after err", active, 0);
    start(1, 0, 0, 0, 0, 0);
    pulse(16'h0800);
    chk("R6 timeout err", done_err, 1);
    chk("R6 timeout class", err_timeout, 1);
    tick();
    start(0, 0, 0, 0, 0, 0);
    pulse(16'h1001);
    chk("R13 err beats ok", done_err, 1);
    chk("R13 ok suppressed", done_ok, 0);
    chk("R6 read timeout class", err_timeout, 1);
    tick();
  endtask

  task automatic t_reject();
    start(0, 0, 0, 0, 0, 0);
    need_busy = 1'b1; has_data = 1'b1; issue = 1'b1;
    tick();
    issue = 1'b0;
    chk("R8 busy_rej", busy_rej, 1);
    chk("R8 mask kept", irq_mask, 16'hE0FE);
    chk("R8 still active", active, 1);
    tick();
    chk("R8 pulse ends", busy_rej, 0);
    evt_in = 16'h0001;
    tick();
    evt_in = '0;
    chk("R8 orig cmd ok", done_ok, 1);
    issue = 1'b1;
    tick();
    issue = 1'b0;
    chk("R8 reject on done cycle", busy_rej, 1);
    chk("R8 not reopened", active, 0);
  endtask

  task automatic t_issue_capture();
    evt_in = 16'h0001;
    start(0, 0, 0, 0, 0, 0);
    evt_in = '0;
    chk("R10 captured", done_ok, 1);
    tick();
  endtask

  task automatic t_idle_and_clear();
    pulse(16'h0001);
    start(0, 0, 0, 0, 0, 0);
    chk("R11 idle event ignored", done_ok, 0);
    pulse(16'h0001);
    tick();
    start(1, 0, 0, 0, 0, 0);
    pulse(16'h0002);
    pulse(16'h0100);
    chk("R6 abort", done_err, 1);
    tick();
    start(1, 0, 0, 0, 0, 0);
    pulse(16'h0001);
    chk("R9 old seen cleared", done_ok, 0);
    pulse(16'h0002);
    chk("R9 fresh ok", done_ok, 1);
    tick();
  endtask

  task automatic t_echo();
    evt_in = 16'h0480;
    tick();
    evt_in = '0;
    chk("R12 echo", evt_clr, 16'h0480);
    tick();
    chk("R12 echo zero", evt_clr, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_simple();
    t_busy_resp();
    t_dma_read_multi();
    t_pio_stream();
    t_errors();
    t_reject();
    t_issue_capture();
    t_idle_and_clear();
    t_echo();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule